// File: doc/BRIEF.md
# Atomic Set/Clear GPIO Register Bank

This block controls 32 general-purpose pins from a simple register read/write bus. Every per-pin feature is kept in its own register. A write to a feature register never replaces the whole word. The low half of the write data sets pins and the high half clears them, so software can change one pin with a single write and needs no read-modify-write. Pins 0-15 form the low bank and pins 16-31 form the high bank. Each bank has a full copy of the register set, and the high bank sits 0x80 above the low one in a 256-byte window.

The block turns the stored features into pad controls: output enable, output level, pull-up and pull-down. Pad inputs are brought into the clock domain through a two-flop synchronizer. They are then gated by the input enable and made readable at a separate read-back offset. There is no state machine: the bus needs no handshake, a write lands on the next clock edge, and read data is registered.

Top module: `gpio_atomic_bank`

## Requirements
- R1: After a synchronous active-low reset, every feature register is 0. All pads are undriven (pad_oe = 0), pad_pu = pad_pd = 0, and bus_rdata = 0.
- R2: A write to a feature register sets bank pin n when data bit n (0-15) is 1 and bit n+16 is 0.
- R3: A write to a feature register clears bank pin n when data bit n+16 is 1 and bit n is 0. Pins whose bits are both 0 keep their value.
- R4: When both bit n and bit n+16 are 1 in one write, pin n of that register keeps its previous value.
- R5: Address bit 7 selects the bank: 0 selects pins 0-15 and 1 selects pins 16-31. A write to one bank never changes the other bank.
- R6: Word offsets within a bank are as follows. Output value is at 0x00, drive enable 0x04, open-drain 0x08, alternate-1 select 0x10, alternate-2 select 0x14, pull-up 0x18, pull-down 0x1C and input enable 0x20. Each reads back its own state at its own offset.
- R7: A read returns the 16-bit bank value in bits 15:0, and bits 31:16 are 0. Data appears on bus_rdata after the clock edge that accepts the read and holds until the next read. Unmapped offsets read 0.
- R8: Writes have no effect when they go to the read-back offset 0x30, to an unmapped offset, or to an address with bits 1:0 not equal to 0.
- R9: pad_oe[p] is 1 only when drive enable is 1 and both alternate selects are 0. When open-drain is 0, pad_out[p] equals the output value.
- R10: When open-drain is 1, pad_out[p] is 0. The pad is driven (low) only when the output value is 0, and it floats when the output value is 1.
- R11: pad_pu and pad_pd follow the pull-up and pull-down registers pin by pin.
- R12: Offset 0x30 reads pad_in through a two-flop synchronizer, ANDed with input enable. A read accepted on the second edge after a pad change still returns the old level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_en | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address in the 256-byte window |
| bus_wdata | input | 32 | Write data: bits 15:0 set, bits 31:16 clear |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad input levels |
| pad_oe | output | 32 | Pad output enable |
| pad_out | output | 32 | Pad output level |
| pad_pu | output | 32 | Pad pull-up enable |
| pad_pd | output | 32 | Pad pull-down enable |

## Verification
A write changes the registers, and through them the pad outputs, on the edge that accepts it. The bench drives each write at a falling edge and checks the pads at the next falling edge. A read is registered, so its data is sampled at the falling edge after the accepting edge. Pad input levels need two edges in the synchronizer before a read can capture them. The bench therefore waits three cycles after changing pad_in before it compares read-back data. One directed check reads too early on purpose and expects the old level.

// File: rtl/gpio_atomic_pkg.sv
package gpio_atomic_pkg;

    localparam int NUM_FEAT = 8;

    typedef enum logic [2:0] {
        FT_VAL, FT_DRV_EN, FT_OPEN_DRAIN, FT_ALT1,
        FT_ALT2, FT_PULL_UP, FT_PULL_DN, FT_IN_EN
    } feat_e;

    typedef enum logic [1:0] {
        AK_FEAT, AK_PINLVL, AK_NONE
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        feat_e     feat;
    } decode_t;

    // Maps an in-bank byte offset to a register; misaligned addresses are unmapped.
    function automatic decode_t decode_off(input logic [6:0] off);
        decode_t d;
        d.kind = AK_FEAT;
        d.feat = FT_VAL;
        if (off[1:0] != 2'b00) begin
            d.kind = AK_NONE;
        end else begin
            case (off[6:2])
                5'd0:    d.feat = FT_VAL;
                5'd1:    d.feat = FT_DRV_EN;
                5'd2:    d.feat = FT_OPEN_DRAIN;
                5'd4:    d.feat = FT_ALT1;
                5'd5:    d.feat = FT_ALT2;
                5'd6:    d.feat = FT_PULL_UP;
                5'd7:    d.feat = FT_PULL_DN;
                5'd8:    d.feat = FT_IN_EN;
                5'd12:   d.kind = AK_PINLVL;
                default: d.kind = AK_NONE;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;

    // R12: the second stage only ever takes what the first stage held
    p_sync_chain_r12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sync_q == $past(meta_q)));

endmodule

// File: rtl/gpio_feat_bank.sv
module gpio_feat_bank
    import gpio_atomic_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  decode_t                      dec,
    input  logic [2*W-1:0]               wdata,
    input  logic [W-1:0]                 pin_lvl,
    output logic [W-1:0]                 rd_word,
    output logic [NUM_FEAT-1:0][W-1:0]   feat_q
);
    logic [W-1:0] regs_q [NUM_FEAT];
    logic [W-1:0] set_bits, clr_bits, set_only, clr_only, both;
    logic [W-1:0] sel_cur, nxt;
    logic         wr_hit;

    assign set_bits = wdata[W-1:0];
    assign clr_bits = wdata[2*W-1:W];
    assign set_only = set_bits & ~clr_bits;
    assign clr_only = clr_bits & ~set_bits;
    assign both     = set_bits & clr_bits;
    assign wr_hit   = wr_en && (dec.kind == AK_FEAT);
    assign sel_cur  = regs_q[dec.feat];
    assign nxt      = (sel_cur & ~clr_only) | set_only;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int f = 0; f < NUM_FEAT; f++) regs_q[f] <= '0;
        end else if (wr_hit) begin
            regs_q[dec.feat] <= nxt;
        end
    end

    always_comb begin
        for (int f = 0; f < NUM_FEAT; f++) feat_q[f] = regs_q[f];
    end

    always_comb begin
        rd_word = '0;
        unique case (dec.kind)
            AK_FEAT:   rd_word = sel_cur;
            AK_PINLVL: rd_word = pin_lvl;
            default:   rd_word = '0;
        endcase
    end

    p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> ((regs_q[$past(dec.feat)] & $past(set_only)) == $past(set_only)));

    p_clr_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> ((regs_q[$past(dec.feat)] & $past(clr_only)) == '0));

    p_both_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (((regs_q[$past(dec.feat)] ^ $past(sel_cur)) & $past(both)) == '0));

    p_no_hit_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(feat_q));

    p_lvl_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_lvl & ~regs_q[FT_IN_EN]) == '0);

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
    parameter int W = 32
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] drv_en,
    input  logic [W-1:0] open_drain,
    input  logic [W-1:0] alt1,
    input  logic [W-1:0] alt2,
    input  logic [W-1:0] pull_up,
    input  logic [W-1:0] pull_dn,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pu,
    output logic [W-1:0] pad_pd
);
    for (genvar p = 0; p < W; p++) begin : g_pin
        logic owned;
        assign owned      = drv_en[p] & ~alt1[p] & ~alt2[p];
        assign pad_oe[p]  = owned & ~(open_drain[p] & val[p]);
        assign pad_out[p] = open_drain[p] ? 1'b0 : val[p];
        assign pad_pu[p]  = pull_up[p];
        assign pad_pd[p]  = pull_dn[p];
    end

    always_comb begin
        p_oe_owned_r9: assert ((pad_oe & ~(drv_en & ~alt1 & ~alt2)) == '0);
        p_od_low_only_r10: assert ((pad_oe & open_drain & (pad_out | val)) == '0);
    end

endmodule

// File: rtl/gpio_atomic_bank.sv
module gpio_atomic_bank
    import gpio_atomic_pkg::*;
#(
    parameter  int NUM_PINS = 32,
    localparam int BANK_W   = NUM_PINS / 2,
    localparam int DATA_W   = 2 * BANK_W,
    localparam int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_pu,
    output logic [NUM_PINS-1:0] pad_pd
);
    localparam int NUM_BANKS = 2;

    decode_t                           dec;
    logic                              bank_idx;
    logic [NUM_PINS-1:0]               pin_sync;
    logic [NUM_FEAT-1:0][NUM_PINS-1:0] feat_all;
    logic [NUM_FEAT-1:0][BANK_W-1:0]   bank_feat [NUM_BANKS];
    logic [BANK_W-1:0]                 bank_rd   [NUM_BANKS];
    logic [DATA_W-1:0]                 rdata_q;

    assign dec      = decode_off(bus_addr[ADDR_W-2:0]);
    assign bank_idx = bus_addr[ADDR_W-1];

    gpio_in_sync #(.W(NUM_PINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (pin_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic              wr_b;
        logic [BANK_W-1:0] lvl_b;
        assign wr_b  = bus_en && bus_we && (bank_idx == 1'(b));
        assign lvl_b = pin_sync[b*BANK_W +: BANK_W] & feat_all[FT_IN_EN][b*BANK_W +: BANK_W];

        gpio_feat_bank #(.W(BANK_W)) u_regs (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_b),
            .dec    (dec),
            .wdata  (bus_wdata),
            .pin_lvl(lvl_b),
            .rd_word(bank_rd[b]),
            .feat_q (bank_feat[b])
        );

        for (genvar f = 0; f < NUM_FEAT; f++) begin : g_feat
            assign feat_all[f][b*BANK_W +: BANK_W] = bank_feat[b][f];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_en && !bus_we) begin
            rdata_q <= {{BANK_W{1'b0}}, bank_rd[bank_idx]};
        end
    end

    assign bus_rdata = rdata_q;

    gpio_pad_drive #(.W(NUM_PINS)) u_pads (
        .val       (feat_all[FT_VAL]),
        .drv_en    (feat_all[FT_DRV_EN]),
        .open_drain(feat_all[FT_OPEN_DRAIN]),
        .alt1      (feat_all[FT_ALT1]),
        .alt2      (feat_all[FT_ALT2]),
        .pull_up   (feat_all[FT_PULL_UP]),
        .pull_dn   (feat_all[FT_PULL_DN]),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .pad_pu    (pad_pu),
        .pad_pd    (pad_pd)
    );

    p_rd_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:BANK_W] == '0);

    p_rd_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && !bus_we) |=> $stable(bus_rdata));

    p_bank_isolation_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && !bank_idx) |=> $stable(bank_feat[1]));

endmodule

// File: tb/tb_gpio_atomic_bank.sv
module tb_gpio_atomic_bank;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_en, bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [31:0] pad_in, pad_oe, pad_out, pad_pu, pad_pd;

    always #5 clk = ~clk;

    gpio_atomic_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] m_feat [8];   // model: 0 val,1 drv,2 od,3 alt1,4 alt2,5 pu,6 pd,7 ie

    function automatic logic [7:0] feat_off(int f);
        case (f)
            0: return 8'h00;  1: return 8'h04;  2: return 8'h08;  3: return 8'h10;
            4: return 8'h14;  5: return 8'h18;  6: return 8'h1C;  default: return 8'h20;
        endcase
    endfunction

    function automatic logic [15:0] upd16(logic [15:0] cur, logic [31:0] w);
        logic [15:0] s, c;
        s = w[15:0];
        c = w[31:16];
        return (cur & ~(c & ~s)) | (s & ~c);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic wr_feat(int f, int bank, logic [31:0] d);
        bus_write(8'(bank * 128) + feat_off(f), d);
        m_feat[f][bank*16 +: 16] = upd16(m_feat[f][bank*16 +: 16], d);
    endtask

    task automatic check_feat(int f, int bank, string req);
        logic [31:0] r;
        bus_read(8'(bank * 128) + feat_off(f), r);
        check(req, r, {16'h0, m_feat[f][bank*16 +: 16]}, $sformatf("feature %0d bank %0d", f, bank));
    endtask

    task automatic check_all_feats(string req);
        for (int f = 0; f < 8; f++)
            for (int b = 0; b < 2; b++) check_feat(f, b, req);
    endtask

    task automatic check_pads(string req);
        logic [31:0] own, e_oe, e_out;
        own   = m_feat[1] & ~m_feat[3] & ~m_feat[4];
        e_oe  = own & ~(m_feat[2] & m_feat[0]);
        e_out = m_feat[0] & ~m_feat[2];
        check(req, pad_oe,  e_oe,  "pad_oe");
        check(req, pad_out, e_out, "pad_out");
        check("R11", pad_pu, m_feat[5], "pad_pu");
        check("R11", pad_pd, m_feat[6], "pad_pd");
    endtask

    task automatic check_level(string req);
        logic [31:0] r;
        bus_read(8'h30, r);
        check(req, r, {16'h0, pad_in[15:0] & m_feat[7][15:0]}, "low read-back");
        bus_read(8'hB0, r);
        check(req, r, {16'h0, pad_in[31:16] & m_feat[7][31:16]}, "high read-back");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd7331));
        for (int f = 0; f < 8; f++) m_feat[f] = '0;
        rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1", pad_oe, 32'h0, "pad_oe after reset");
        check("R1", bus_rdata, 32'h0, "rdata after reset");
        check_pads("R1");
        check_all_feats("R1");

        // R2 / R3 / R4 on the low bank
        wr_feat(0, 0, 32'h0000_00A5);
        check_feat(0, 0, "R2");
        wr_feat(0, 0, 32'h0021_0000);
        check_feat(0, 0, "R3");
        check("R3", m_feat[0][15:0], 16'h0084, "model low value");
        wr_feat(0, 0, 32'h0006_0006);
        check_feat(0, 0, "R4");
        // same on the high bank
        wr_feat(1, 1, 32'h0000_F00F);
        wr_feat(1, 1, 32'h000F_0000);
        wr_feat(1, 1, 32'h8001_8001);
        check_feat(1, 1, "R4");

        // R5: high bank write leaves low bank untouched
        wr_feat(0, 1, 32'h0000_FFFF);
        check_feat(0, 0, "R5");
        check_feat(0, 1, "R5");

        // R6: every offset in both banks
        for (int f = 0; f < 8; f++)
            for (int b = 0; b < 2; b++) wr_feat(f, b, 32'h0000_0001 << (f + 4 * b));
        check_all_feats("R6");

        // R8: writes to read-back, unmapped and misaligned addresses
        bus_write(8'h30, 32'h0000_FFFF);
        bus_write(8'h0C, 32'h0000_FFFF);
        bus_write(8'hC4, 32'h0000_FFFF);
        bus_write(8'h02, 32'h0000_FFFF);
        bus_write(8'h85, 32'hFFFF_0000);
        check_all_feats("R8");
        check_pads("R8");

        // R7: unmapped reads and upper half
        bus_read(8'h0C, r);
        check("R7", r, 32'h0, "unmapped read");
        wr_feat(0, 0, 32'h0000_FFFF);
        bus_read(8'h00, r);
        check("R7", r, 32'h0000_FFFF, "upper half zero");
        repeat (3) @(negedge clk);
        check("R7", bus_rdata, 32'h0000_FFFF, "rdata held");

        // R9 / R10 / R11 directed pad cases
        for (int f = 0; f < 8; f++) begin
            wr_feat(f, 0, 32'hFFFF_0000);
            wr_feat(f, 1, 32'hFFFF_0000);
        end
        wr_feat(1, 0, 32'h0000_FFFF);
        wr_feat(0, 0, 32'h0000_00F0);
        check_pads("R9");
        wr_feat(3, 0, 32'h0000_0011);
        wr_feat(4, 0, 32'h0000_0022);
        check_pads("R9");
        wr_feat(2, 0, 32'h0000_3C00 | 32'h0000_00C0);
        check_pads("R10");
        check("R10", pad_out & m_feat[2], 32'h0, "open-drain level");
        wr_feat(5, 1, 32'h0000_0F0F);
        wr_feat(6, 1, 32'h0000_F0F0);
        check_pads("R11");

        // R12: synchronizer latency and gating
        wr_feat(7, 0, 32'h0000_00FF);
        wr_feat(7, 1, 32'h0000_FFFF);
        @(negedge clk);
        pad_in = 32'hA5A5_5A5A;
        bus_read(8'h30, r);
        check("R12", r, 32'h0, "read too early");
        repeat (2) @(negedge clk);
        check_level("R12");

        // random mix
        for (int i = 0; i < 300; i++) begin
            int f, b;
            f = int'($urandom_range(0, 7));
            b = int'($urandom_range(0, 1));
            wr_feat(f, b, $urandom);
            check_feat(int'($urandom_range(0, 7)), int'($urandom_range(0, 1)), "R6");
            check_pads("R9");
            if (i % 10 == 0) begin
                pad_in = $urandom;
                repeat (3) @(negedge clk);
                check_level("R12");
            end
        end

        finish_run();
    end

endmodule